// File: doc/BRIEF.md
# Strided Sliding Window Generator

This block turns a raster-ordered stream of 16-bit Q8.8 pixels from a single feature map into a stream of complete KH×KW windows. The windows are spaced SH rows apart vertically and SW columns apart horizontally, and the two strides are set independently. The block takes in one pixel per clock whenever the downstream side can accept. It presents a window only when the newest pixel lands on a stride-aligned position. In that case the whole window appears in parallel on one wide output word.

The block keeps the KH−1 most recent rows in one line buffer per row, indexed by column. The live window sits in a shift-register array that moves one column to the left on every accepted pixel. A row counter and a column counter track the position in the frame. Each counter has a stride phase beside it, so the block needs no divider. A start-of-frame flag forces the current pixel to row 0, column 0. Backpressure on the output holds the pending window and stops pixel intake without disturbing the stored rows.

Top module: `slide_win_gen`

## Requirements
- R1: After reset, out_valid is 0 and in_ready is 1.
- R2: In an emitted window, the word at bits [(i*KW+j)*16 +: 16] is the pixel at frame row top+i and column left+j, where top = row−(KH−1) and left = col−(KW−1) of the newest pixel. Index 0 is the oldest row and the leftmost column. Pixel words pass through unchanged.
- R3: A window is emitted exactly when the accepted pixel has row ≥ KH−1 with (row−KH+1) mod SH = 0 and col ≥ KW−1 with (col−KW+1) mod SW = 0. Windows come out in raster order, and a full frame gives ((IMG_H−KH)/SH+1)·((IMG_W−KW)/SW+1) of them.
- R4: The vertical stride SH and the horizontal stride SW act independently. With the defaults SH=2 and SW=1, window tops fall on rows 0, 2 and 4, and window left edges fall on every column from 0 to 5.
- R5: A pixel that arrives with in_sof=1 is taken as row 0, column 0, whatever the counters hold. Without in_sof, the position wraps to row 0, column 0 after row IMG_H−1, column IMG_W−1.
- R6: While out_valid=1 and out_ready=0, out_valid stays 1, out_win stays unchanged and in_ready is 0. No pixel is lost.
- R7: While out_ready is held at 1, in_ready stays 1, so one pixel is accepted on every cycle that in_valid is 1.
- R8: No emitted window contains pixels from two different rows of the same window column, or from two frames. This holds even when in_sof cuts a frame short.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Pixel present |
| in_ready | output | 1 | Block can take a pixel this cycle |
| in_sof | input | 1 | Pixel is the first of a frame |
| in_data | input | DATA_W | Pixel, Q8.8 |
| out_valid | output | 1 | Window present |
| out_ready | input | 1 | Downstream takes the window |
| out_win | output | KH*KW*DATA_W | Window words, row-major, oldest row and leftmost column at index 0 |

## Verification
The hardest case to reach is a window becoming due while the previous window is still held by backpressure. This matters most when in_sof arrives in the middle of a frame and the line buffers still hold the old frame's rows. The stall scenario drives in_valid and out_ready from independent pseudo-random bit patterns. Because of this, stalls fall both on emitting pixels and on non-emitting pixels, and the bench checks that the held word stays stable. A separate scenario stops a frame after three rows and restarts it with a new pixel pattern. Every window of the new frame must then carry only the new values.

// File: rtl/slide_win_pkg.sv
// Package: shared pixel format for the sliding window generator.
// Assumes Q8.8 fixed point: 8 integer bits above 8 fraction bits.
package slide_win_pkg;
    localparam int PIX_INT_W  = 8;
    localparam int PIX_FRAC_W = 8;
    localparam int PIX_W      = PIX_INT_W + PIX_FRAC_W;
    typedef logic [PIX_W-1:0] pix_t;
endpackage

// File: rtl/slide_win_pos.sv
// Module: slide_win_pos
// Tracks the raster position of the incoming pixel and decides whether the
// pixel completes a stride-aligned window. Per-axis stride phases replace
// any modulo arithmetic. Assumes IMG_W >= KW, IMG_H >= KH, strides >= 1.
module slide_win_pos #(
    parameter int IMG_W = 8,
    parameter int IMG_H = 7,
    parameter int KH    = 3,
    parameter int KW    = 3,
    parameter int SH    = 2,
    parameter int SW    = 1
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               acc,
    input  logic                               sof,
    output logic [(IMG_W>1?$clog2(IMG_W):1)-1:0] col_e,
    output logic                               hit
);
    localparam int CW  = (IMG_W > 1) ? $clog2(IMG_W) : 1;
    localparam int RW  = (IMG_H > 1) ? $clog2(IMG_H) : 1;
    localparam int CPW = (SW > 1) ? $clog2(SW) : 1;
    localparam int RPW = (SH > 1) ? $clog2(SH) : 1;
    localparam logic [CW-1:0]  COL_LAST = CW'(IMG_W - 1);
    localparam logic [RW-1:0]  ROW_LAST = RW'(IMG_H - 1);
    localparam logic [CW-1:0]  COL_K    = CW'(KW - 1);
    localparam logic [RW-1:0]  ROW_K    = RW'(KH - 1);
    localparam logic [CPW-1:0] CPH_LAST = CPW'(SW - 1);
    localparam logic [RPW-1:0] RPH_LAST = RPW'(SH - 1);

    logic [CW-1:0]  col_q;
    logic [RW-1:0]  row_q, row_e;
    logic [CPW-1:0] cph_q, cph_e;
    logic [RPW-1:0] rph_q, rph_e;

    // Effective position: start-of-frame overrides the stored counters.
    always_comb begin
        col_e = sof ? '0 : col_q;
        row_e = sof ? '0 : row_q;
        cph_e = sof ? '0 : cph_q;
        rph_e = sof ? '0 : rph_q;
        hit   = (col_e >= COL_K) && (cph_e == '0) &&
                (row_e >= ROW_K) && (rph_e == '0);
    end

    // Advance position and stride phases on each accepted pixel.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            col_q <= '0;
            row_q <= '0;
            cph_q <= '0;
            rph_q <= '0;
        end else if (acc) begin
            if (col_e == COL_LAST) begin
                col_q <= '0;
                cph_q <= '0;
                if (row_e == ROW_LAST) begin
                    row_q <= '0;
                    rph_q <= '0;
                end else begin
                    row_q <= row_e + 1'b1;
                    if (row_e >= ROW_K)
                        rph_q <= (rph_e == RPH_LAST) ? '0 : rph_e + 1'b1;
                    else
                        rph_q <= '0;
                end
            end else begin
                col_q <= col_e + 1'b1;
                row_q <= row_e;
                rph_q <= rph_e;
                if (col_e >= COL_K)
                    cph_q <= (cph_e == CPH_LAST) ? '0 : cph_e + 1'b1;
                else
                    cph_q <= '0;
            end
        end
    end

    p_col_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        col_q <= COL_LAST && row_q <= ROW_LAST);
    p_idle_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !acc |=> $stable(col_q) && $stable(row_q));
    p_phase_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cph_q <= CPH_LAST && rph_q <= RPH_LAST);
endmodule

// File: rtl/slide_win_line.sv
// Module: slide_win_line
// One row of history: a column-addressed store with an asynchronous read of
// the addressed column and a write of the same column on accept.
// Assumes read-before-write within the cycle (old value is read).
module slide_win_line #(
    parameter int DEPTH = 8,
    parameter int DW    = 16,
    parameter int AW    = 3
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] dout
);
    logic [DW-1:0] mem [DEPTH];

    // Read the stored pixel for the current column.
    assign dout = mem[addr];

    // Replace the column's pixel with the one a row younger.
    always_ff @(posedge clk) begin
        if (we) mem[addr] <= din;
    end
endmodule

// File: rtl/slide_win_regs.sv
// Module: slide_win_regs
// Holds the live KH x KW window. Each shift moves every row one column left
// and loads the new column at the right edge. win_nx shows the window that
// the next shift will produce. Row 0 is the oldest row.
module slide_win_regs #(
    parameter int KH = 3,
    parameter int KW = 3,
    parameter int DW = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  shift,
    input  logic [KH*DW-1:0]      col_in,
    output logic [KH*KW*DW-1:0]   win_nx
);
    logic [DW-1:0] win_q [KH][KW];
    logic [DW-1:0] nx    [KH][KW];

    for (genvar i = 0; i < KH; i++) begin : g_row
        for (genvar j = 0; j < KW; j++) begin : g_col
            if (j == KW - 1) begin : g_edge
                assign nx[i][j] = col_in[i*DW +: DW];
            end else begin : g_inner
                assign nx[i][j] = win_q[i][j+1];
            end
            assign win_nx[(i*KW+j)*DW +: DW] = nx[i][j];

            // Load the shifted window element on each accepted pixel.
            always_ff @(posedge clk) begin
                if (!rst_n)     win_q[i][j] <= '0;
                else if (shift) win_q[i][j] <= nx[i][j];
            end
        end
    end

    p_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !shift |=> $stable(win_q[0][0]) && $stable(win_q[KH-1][KW-1]));
endmodule

// File: rtl/slide_win_gen.sv
// Module: slide_win_gen (top)
// Raster pixel stream in, strided KH x KW windows out, one window per word.
// One output register holds the window; intake stalls while it is blocked.
// Assumes KH >= 2 and that the frame geometry matches the parameters.
module slide_win_gen #(
    parameter int DATA_W = slide_win_pkg::PIX_W,
    parameter int IMG_W  = 8,
    parameter int IMG_H  = 7,
    parameter int KH     = 3,
    parameter int KW     = 3,
    parameter int SH     = 2,
    parameter int SW     = 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      in_valid,
    output logic                      in_ready,
    input  logic                      in_sof,
    input  logic [DATA_W-1:0]         in_data,
    output logic                      out_valid,
    input  logic                      out_ready,
    output logic [KH*KW*DATA_W-1:0]   out_win
);
    localparam int CW    = (IMG_W > 1) ? $clog2(IMG_W) : 1;
    localparam int NLINE = KH - 1;
    localparam int WIN_W = KH * KW * DATA_W;

    logic             acc, hit;
    logic [CW-1:0]    col_e;
    logic [KH*DATA_W-1:0] col_v;
    logic [WIN_W-1:0] win_nx;

    assign in_ready = !out_valid || out_ready;
    assign acc      = in_valid && in_ready;

    slide_win_pos #(
        .IMG_W(IMG_W), .IMG_H(IMG_H), .KH(KH), .KW(KW), .SH(SH), .SW(SW)
    ) pos_i (
        .clk(clk), .rst_n(rst_n), .acc(acc), .sof(in_sof),
        .col_e(col_e), .hit(hit)
    );

    // Newest row of the column is the incoming pixel.
    assign col_v[(KH-1)*DATA_W +: DATA_W] = in_data;

    for (genvar i = 0; i < NLINE; i++) begin : g_line
        slide_win_line #(.DEPTH(IMG_W), .DW(DATA_W), .AW(CW)) line_i (
            .clk(clk), .we(acc), .addr(col_e),
            .din(col_v[(i+1)*DATA_W +: DATA_W]),
            .dout(col_v[i*DATA_W +: DATA_W])
        );
    end

    slide_win_regs #(.KH(KH), .KW(KW), .DW(DATA_W)) regs_i (
        .clk(clk), .rst_n(rst_n), .shift(acc), .col_in(col_v), .win_nx(win_nx)
    );

    // Output register: capture an aligned window, release on handshake.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_win   <= '0;
        end else if (acc && hit) begin
            out_valid <= 1'b1;
            out_win   <= win_nx;
        end else if (out_ready) begin
            out_valid <= 1'b0;
        end
    end

    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_win));
    p_new_after_take_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) |-> $past(in_valid && in_ready));
    p_win_changes_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(out_win) |-> $past(in_valid) && out_valid);
endmodule

// File: tb/slide_win_gen_tb.sv
// Directed bench for slide_win_gen: one task per scenario.
module slide_win_gen_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int W = 8, H = 7, KH = 3, KW = 3, SH = 2, SW = 1, DW = 16;
    localparam int WW = KH * KW * DW;
    localparam int FULL_CNT = ((H - KH) / SH + 1) * ((W - KW) / SW + 1);

    logic clk = 0, rst_n = 0;
    logic in_valid = 0, in_sof = 0, out_ready = 0;
    logic [DW-1:0] in_data = '0;
    logic in_ready, out_valid;
    logic [WW-1:0] out_win;

    slide_win_gen #(.DATA_W(DW), .IMG_W(W), .IMG_H(H), .KH(KH), .KW(KW),
                    .SH(SH), .SW(SW)) dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_sof(in_sof), .in_data(in_data), .out_valid(out_valid),
        .out_ready(out_ready), .out_win(out_win)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int total = 0, bad = 0, cycles = 0, out_cnt = 0, rdy_low = 0;
    bit tmo = 0, hold_pend = 0;
    logic [WW-1:0] held;
    logic [WW-1:0] exp_q [$];
    logic [15:0] lfsr = 16'hACE1;

    function automatic logic [15:0] pix(int s, int r, int c);
        return 16'((s << 8) | (r << 4) | c);
    endfunction

    function automatic void chk(bit ok, string req, logic [WW-1:0] act, logic [WW-1:0] expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, expv);
        end
    endfunction

    // Push expected windows (R3 position rule, R2 word order) for a frame.
    task automatic expect_frame(int s, int rows);
        for (int r = 0; r < rows; r++)
            for (int c = 0; c < W; c++)
                if (r >= KH-1 && (r-KH+1) % SH == 0 && c >= KW-1 && (c-KW+1) % SW == 0) begin
                    logic [WW-1:0] w;
                    for (int i = 0; i < KH; i++)
                        for (int j = 0; j < KW; j++)
                            w[(i*KW+j)*DW +: DW] = pix(s, r-KH+1+i, c-KW+1+j);
                    exp_q.push_back(w);
                end
    endtask

    // One cycle: drive at negedge, record handshakes, advance.
    task automatic step(input logic iv, input logic isof, input logic [15:0] d,
                        input logic ordy, output logic took);
        in_valid = iv; in_sof = isof; in_data = d; out_ready = ordy;
        #1;
        if (hold_pend)
            chk(out_valid && out_win == held, "R6 held window", out_win, held);
        hold_pend = out_valid && !out_ready;
        held = out_win;
        if (ordy && !in_ready) rdy_low++;
        took = iv && in_ready;
        if (out_valid && out_ready) begin
            out_cnt++;
            if (exp_q.size() == 0)
                chk(0, "R3 unexpected window", out_win, '0);
            else begin
                logic [WW-1:0] e;
                e = exp_q.pop_front();
                chk(out_win == e, "R2 R8 window content", out_win, e);
            end
        end
        cycles++;
        if (cycles > 150000) tmo = 1;
        @(negedge clk);
    endtask

    task automatic send_rows(int s, int rows, bit use_sof, bit gaps);
        logic took;
        for (int r = 0; r < rows; r++)
            for (int c = 0; c < W; c++) begin
                took = 0;
                while (!took && !tmo) begin
                    logic iv, ordy;
                    lfsr = {lfsr[14:0], lfsr[15]^lfsr[13]^lfsr[12]^lfsr[10]};
                    iv   = gaps ? lfsr[0] | lfsr[3] : 1'b1;
                    ordy = gaps ? lfsr[5] : 1'b1;
                    step(iv, use_sof && r == 0 && c == 0, pix(s, r, c), ordy, took);
                end
            end
    endtask

    task automatic drain();
        logic took;
        for (int k = 0; k < 6; k++) step(0, 0, '0, 1, took);
    endtask

    task automatic t_reset();
        chk(out_valid == 0, "R1 out_valid after reset", WW'(out_valid), '0);
        chk(in_ready == 1, "R1 in_ready after reset", WW'(in_ready), WW'(1));
    endtask

    task automatic t_plain();
        int c0 = out_cnt;
        rdy_low = 0;
        expect_frame(1, H);
        send_rows(1, H, 1, 0);
        drain();
        chk(out_cnt - c0 == FULL_CNT, "R3 R4 windows per frame", WW'(out_cnt - c0), WW'(FULL_CNT));
        chk(rdy_low == 0, "R7 in_ready low with out_ready high", WW'(rdy_low), '0);
        chk(exp_q.size() == 0, "R3 missing windows", WW'(exp_q.size()), '0);
    endtask

    task automatic t_wrap_no_sof();
        int c0 = out_cnt;
        expect_frame(2, H);
        send_rows(2, H, 0, 0);
        drain();
        chk(out_cnt - c0 == FULL_CNT, "R5 wrap without sof", WW'(out_cnt - c0), WW'(FULL_CNT));
    endtask

    task automatic t_stall();
        int c0 = out_cnt;
        expect_frame(3, H);
        send_rows(3, H, 1, 1);
        drain();
        chk(out_cnt - c0 == FULL_CNT, "R6 no window lost under stall", WW'(out_cnt - c0), WW'(FULL_CNT));
        chk(exp_q.size() == 0, "R6 all windows delivered", WW'(exp_q.size()), '0);
    endtask

    task automatic t_sof_cut();
        int c0 = out_cnt;
        expect_frame(4, 3);
        send_rows(4, 3, 1, 0);
        expect_frame(5, H);
        send_rows(5, H, 1, 0);
        drain();
        chk(out_cnt - c0 == (W-KW+1) + FULL_CNT, "R5 R8 sof restart count",
            WW'(out_cnt - c0), WW'((W-KW+1) + FULL_CNT));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        #1;
        t_reset();
        @(negedge clk);
        t_plain();
        t_wrap_no_sof();
        t_stall();
        t_sof_cut();
        if (tmo) begin
            total++; bad++;
            $display("FAIL watchdog act=%0d exp=<150000", cycles);
        end
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule